// File: doc/BRIEF.md
# Sliding-Window Jet Finder with Tau Tagging

The block takes one complete grid of calorimeter region energies per clock and, for every region position in the grid, decides whether a jet sits there. Each region already holds the transverse-energy sum of a 4x4 patch of trigger towers. The candidate window is the 3x3 block of regions centred on the position, so it covers 12x12 towers. The window moves one region at a time, which gives one candidate per region.

A position reports a jet only when its central region dominates the other eight regions in its window. For each jet the block reports the energy summed over the nine regions. It also raises a tau flag when none of the nine regions carries its veto bit. A region that falls outside the grid counts as zero energy with its veto clear.

Results come out three clocks after the grid is presented. A new grid can be accepted on every clock.

Top module: `jet_window_finder`

## Requirements
- R1: While reset is held and after it is released with no input, out_valid is 0 and out_jet, out_tau and out_energy are all zero.
- R2: A grid presented with in_valid high on a clock edge produces its results, with out_valid high, exactly three clock edges later. Grids presented on consecutive clocks come out on consecutive clocks in the same order.
- R3: Region (r,c) sits at index p = r*COLS + c, with row 0 on top. Its energy is in_energy[p*EW +: EW], its overflow bit is in_ovf[p] and its veto bit is in_veto[p]. out_jet[p] is 1 only when the centre region's energy beats every one of the eight neighbours in its window.
- R4: Ties are broken by position. Against the three neighbours in the row above, and against the left neighbour in the same row, the centre must be strictly greater. Against the right neighbour and the three neighbours in the row below, greater-or-equal is enough. As a result, a plateau of equal maxima yields exactly one jet, at its top-left member, and no two jets are ever within one region of each other.
- R5: For a jet at p, out_energy[p*SW +: SW] (SW = EW+4) is the unsigned sum of the nine window energies.
- R6: If any of the nine window regions has its overflow bit set, a jet's energy reads all ones (16383 at default widths).
- R7: out_tau[p] is 1 only when out_jet[p] is 1 and all nine window regions have their veto bit clear.
- R8: A position without a jet reports zero energy and a clear tau bit. When out_valid is 0, every output bit is zero.
- R9: Window members outside the grid count as energy 0, overflow clear and veto clear, so positions on the edges and corners can report jets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Grid on the inputs is valid this clock |
| in_energy | input | ROWS*COLS*EW | Region energies, region p at bits p*EW |
| in_ovf | input | ROWS*COLS | Per-region overflow bit |
| in_veto | input | ROWS*COLS | Per-region tau veto bit |
| out_valid | output | 1 | Result grid valid |
| out_jet | output | ROWS*COLS | Jet found at each position |
| out_energy | output | ROWS*COLS*(EW+4) | Nine-region jet energy per position |
| out_tau | output | ROWS*COLS | Tau-like flag per position |

## Verification
The latency assertion assumes that in_valid is a clean 0 or 1 from the first edge after reset. The bench holds it low through reset and drives it only on falling edges.

The range assertion on the reported energy relies on region energies staying within EW bits. This holds at the ports by construction, so the bench's random stimulus draws values within that width. It mostly uses small values so that ties, plateaus and veto or overflow bits inside windows come up often.

// File: rtl/jet_window_finder.sv
module jet_window_finder #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int EW   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ROWS*COLS*EW-1:0] in_energy,
  input  logic [ROWS*COLS-1:0]   in_ovf,
  input  logic [ROWS*COLS-1:0]   in_veto,
  output logic                   out_valid,
  output logic [ROWS*COLS-1:0]   out_jet,
  output logic [ROWS*COLS*(EW+4)-1:0] out_energy,
  output logic [ROWS*COLS-1:0]   out_tau
);
  localparam int N  = ROWS*COLS;
  localparam int SW = EW+4;
  localparam logic [SW-1:0] SUM_MAX = SW'(9*((1<<EW)-1));

  logic          v1, v2;
  logic [N*EW-1:0] e1;
  logic [N-1:0]  o1, t1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; e1 <= '0; o1 <= '0; t1 <= '0;
    end else begin
      v1 <= in_valid; e1 <= in_energy; o1 <= in_ovf; t1 <= in_veto;
    end

  logic [EW-1:0] nb_e [N][9];
  logic          nb_o [N][9];
  logic          nb_t [N][9];

  for (genvar gp = 0; gp < N; gp++) begin : g_pos
    for (genvar gk = 0; gk < 9; gk++) begin : g_nb
      localparam int R = gp/COLS + gk/3 - 1;
      localparam int C = gp%COLS + gk%3 - 1;
      if (R >= 0 && R < ROWS && C >= 0 && C < COLS) begin : g_in
        assign nb_e[gp][gk] = e1[(R*COLS+C)*EW +: EW];
        assign nb_o[gp][gk] = o1[R*COLS+C];
        assign nb_t[gp][gk] = t1[R*COLS+C];
        if (gk > 4) begin : g_pair
          AST_ONE_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_jet[gp] && out_jet[R*COLS+C])); // R4
        end
      end else begin : g_out
        assign nb_e[gp][gk] = '0;
        assign nb_o[gp][gk] = 1'b0;
        assign nb_t[gp][gk] = 1'b0;
      end
    end

    AST_NO_JET_NO_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_jet[gp] |-> (out_energy[gp*SW +: SW] == '0 && !out_tau[gp])); // R8
    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_energy[gp*SW +: SW] <= SUM_MAX) || (out_energy[gp*SW +: SW] == '1)); // R6
  end

  logic [N-1:0]  jet_c, ovf_c, clr_c;
  logic [SW-1:0] sum_c [N];

  always_comb
    for (int p = 0; p < N; p++) begin
      jet_c[p] = 1'b1;
      ovf_c[p] = 1'b0;
      clr_c[p] = 1'b1;
      sum_c[p] = '0;
      for (int k = 0; k < 9; k++) begin
        sum_c[p] = sum_c[p] + SW'(nb_e[p][k]);
        ovf_c[p] = ovf_c[p] | nb_o[p][k];
        clr_c[p] = clr_c[p] & ~nb_t[p][k];
        if (k < 4)      jet_c[p] = jet_c[p] & (nb_e[p][4] >  nb_e[p][k]);
        else if (k > 4) jet_c[p] = jet_c[p] & (nb_e[p][4] >= nb_e[p][k]);
      end
    end

  logic [N-1:0]  j2, o2, c2;
  logic [SW-1:0] s2 [N];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v2 <= 1'b0; j2 <= '0; o2 <= '0; c2 <= '0;
      for (int p = 0; p < N; p++) s2[p] <= '0;
    end else begin
      v2 <= v1; j2 <= jet_c; o2 <= ovf_c; c2 <= clr_c;
      for (int p = 0; p < N; p++) s2[p] <= sum_c[p];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_jet <= '0; out_tau <= '0; out_energy <= '0;
    end else begin
      out_valid <= v2;
      for (int p = 0; p < N; p++) begin
        out_jet[p] <= v2 & j2[p];
        out_tau[p] <= v2 & j2[p] & c2[p];
        out_energy[p*SW +: SW] <= (v2 && j2[p]) ? (o2[p] ? '1 : s2[p]) : '0;
      end
    end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2
  AST_TAU_NEEDS_JET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tau & ~out_jet) == '0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_jet == '0 && out_tau == '0 && out_energy == '0)); // R8
endmodule

// File: tb/jet_window_finder_tb.sv
`timescale 1ns/1ps
module jet_window_finder_tb;
  localparam int ROWS = 4, COLS = 4, EW = 10;
  localparam int N = ROWS*COLS, SW = EW+4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [N*EW-1:0] in_energy = '0;
  logic [N-1:0] in_ovf = '0, in_veto = '0;
  logic out_valid;
  logic [N-1:0] out_jet, out_tau;
  logic [N*SW-1:0] out_energy;

  jet_window_finder #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_energy(in_energy),
    .in_ovf(in_ovf), .in_veto(in_veto), .out_valid(out_valid), .out_jet(out_jet),
    .out_energy(out_energy), .out_tau(out_tau));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [N*EW-1:0] ge [0:63];
  logic [N-1:0] go [0:63], gv [0:63];
  string gt [0:63];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic void model(input logic [N*EW-1:0] e, input logic [N-1:0] o,
      input logic [N-1:0] v, output logic [N-1:0] j, output logic [N*SW-1:0] s,
      output logic [N-1:0] t);
    for (int p = 0; p < N; p++) begin
      int r, c, ce, sum;
      bit win, ov, vt;
      r = p / COLS; c = p % COLS;
      ce = int'(e[p*EW +: EW]);
      win = 1; ov = 0; vt = 0; sum = 0;
      for (int dr = -1; dr <= 1; dr++)
        for (int dc = -1; dc <= 1; dc++) begin
          int rr, cc, x;
          bit xo, xv;
          rr = r + dr; cc = c + dc; x = 0; xo = 0; xv = 0;
          if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) begin
            x  = int'(e[(rr*COLS+cc)*EW +: EW]);
            xo = o[rr*COLS+cc];
            xv = v[rr*COLS+cc];
          end
          if (dr < 0 || (dr == 0 && dc < 0)) win = win & (ce > x);
          else if (!(dr == 0 && dc == 0)) win = win & (ce >= x);
          sum += x; ov |= xo; vt |= xv;
        end
      j[p] = win;
      t[p] = win && !vt;
      s[p*SW +: SW] = win ? (ov ? '1 : SW'(sum)) : '0;
    end
  endfunction

  task automatic check_grid(input int i);
    logic [N-1:0] ej, et;
    logic [N*SW-1:0] es;
    model(ge[i], go[i], gv[i], ej, es, et);
    checks++;
    if (out_valid !== 1'b1 || out_jet !== ej || out_tau !== et || out_energy !== es) begin
      errors++;
      $display("FAIL %s grid %0d: got v=%b jet=%h tau=%h energy=%h, expected v=1 jet=%h tau=%h energy=%h",
        gt[i], i, out_valid, out_jet, out_tau, out_energy, ej, et, es);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (out_valid !== 1'b0 || out_jet !== '0 || out_tau !== '0 || out_energy !== '0) begin
      errors++;
      $display("FAIL %s idle: got v=%b jet=%h tau=%h energy=%h, expected all zero",
        tag, out_valid, out_jet, out_tau, out_energy);
    end
  endtask

  task automatic run_stream(input int k);
    for (int n = 0; n < k + 3; n++) begin
      @(negedge clk);
      if (n >= 3) check_grid(n - 3);
      if (n < k) begin
        in_valid = 1'b1; in_energy = ge[n]; in_ovf = go[n]; in_veto = gv[n];
      end else begin
        in_valid = 1'b0; in_energy = '0; in_ovf = '0; in_veto = '0;
      end
    end
  endtask

  task automatic blank(input int i, input string tag);
    ge[i] = '0; go[i] = '0; gv[i] = '0; gt[i] = tag;
  endtask

  task automatic put(input int i, input int r, input int c, input int val);
    ge[i][(r*COLS+c)*EW +: EW] = EW'(val);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    blank(0, "R8 zero grid");
    blank(1, "R3 R5 single peak");
    for (int p = 0; p < N; p++) put(1, p / COLS, p % COLS, 1);
    put(1, 1, 1, 9);
    blank(2, "R4 plateau");
    put(2, 1, 1, 5); put(2, 1, 2, 5); put(2, 2, 1, 5); put(2, 2, 2, 5);
    blank(3, "R7 R9 corner");
    put(3, 3, 3, 100); put(3, 2, 3, 30); gv[3][0] = 1'b1;
    blank(4, "R6 overflow");
    put(4, 2, 2, 1023); put(4, 1, 1, 2); go[4][1*COLS+1] = 1'b1;
    blank(5, "R7 veto");
    put(5, 1, 2, 50); gv[5][2*COLS+3] = 1'b1; put(5, 3, 0, 40);
    blank(6, "R4 R9 flat full");
    for (int p = 0; p < N; p++) put(6, p / COLS, p % COLS, 1023);
    run_stream(7);

    for (int i = 0; i < 48; i++) begin
      blank(i, "R2 R3 random");
      for (int p = 0; p < N; p++) begin
        put(i, p / COLS, p % COLS, ($urandom_range(0, 3) == 0) ?
            int'($urandom_range(0, 1023)) : int'($urandom_range(0, 6)));
        gv[i][p] = ($urandom_range(0, 5) == 0);
      end
      if ($urandom_range(0, 7) == 0) go[i][$urandom_range(0, N-1)] = 1'b1;
    end
    run_stream(48);
    @(negedge clk);
    check_idle("R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule